// File: doc/BRIEF.md
# E1 Remote Alarm Debouncer

This block watches the far-end alarm flag that an E1 receiver finds in time slot 0 of the frames that do not carry the alignment word. That flag appears once every two frames. The block filters it so that a single corrupted bit cannot toggle the alarm seen by the rest of the receiver. A recovered bit stream enters together with a strobe from the framer. The strobe is high for the eight bit periods of time slot 0 in each non-alignment frame. The block picks the third of those eight bits as the alarm sample.

The filtered alarm level moves to a new value only after that value has arrived in a run of identical samples. A control input sets the run length to two or three samples. When the framer reports that alignment is lost, the run is discarded and the alarm level is frozen.

The core is a three-state machine. RA_IDLE means no disagreeing sample is pending. RA_SEEN1 means one sample that differs from the output has arrived. RA_SEEN2 means two such samples have arrived in a row.

The transitions are:
- IDLE_TO_SEEN1 fires on a disagreeing sample.
- SEEN1_COMMIT fires on a second disagreeing sample at depth two. It updates the output and returns to RA_IDLE.
- SEEN1_TO_SEEN2 fires on a second disagreeing sample at depth three.
- SEEN2_COMMIT fires on a third disagreeing sample. It updates the output and returns to RA_IDLE.
- AGREE_CLEAR fires from any state when a sample equals the output. It returns to RA_IDLE.
- ALIGN_CLEAR fires from any state while alignment is invalid. It returns to RA_IDLE.

Top module: `e1_remote_alarm_debounce`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, `remote_alarm` is 0 until a qualifying run of samples arrives.
- R2: Only the bit present during the third consecutive cycle of an `nfas_strobe` high window is taken as the alarm sample. The first cycle of the window counts as the first. The other seven bits of the window have no effect on `remote_alarm`.
- R3: With `deep_sel` = 0, `remote_alarm` takes the sampled value once two consecutive samples carry that value.
- R4: With `deep_sel` = 1, `remote_alarm` takes the sampled value only once three consecutive samples carry that value. Two such samples leave it unchanged.
- R5: `remote_alarm` holds its value until the run condition is met. A run that is broken by a sample equal to the current output starts again from one.
- R6: Cycles with `nfas_strobe` low, which cover alignment frames and the other time slots, neither advance nor clear the run, however many of them pass between two samples.
- R7: While `align_ok` is 0, the run is cleared and `remote_alarm` keeps its value. After alignment returns, a full new run is needed.
- R8: `deep_sel` is read at the sample cycle. A change to it applies from the next sample, and samples already counted still count toward the new depth.
- R9: `remote_alarm` changes on the clock edge that captures the completing sample. The new value is visible in the cycle after that sample bit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered, frame-aligned E1 data bit |
| nfas_strobe | input | 1 | High for the eight time slot 0 bits of each non-alignment frame |
| deep_sel | input | 1 | Run length select: 0 for two samples, 1 for three samples |
| align_ok | input | 1 | Frame alignment valid from the framer |
| remote_alarm | output | 1 | Debounced far-end alarm level |

## Verification
In every strobe window, the seven bits around the sample carry the opposite value. A design that tapped the wrong bit position would therefore show the alarm flipping after the first window. Long stretches with the strobe low are placed between samples. A design that reset the run on alignment frames would never commit across those gaps. Alignment loss is inserted in the middle of a run. A design that kept the count would commit one sample early, and one that released the output would lose the alarm. The depth select is switched in the middle of a run in both directions. Commit cycles are sampled on both sides of the completing bit, which exposes an extra pipeline stage.

// File: rtl/e1ra_pkg.sv
package e1ra_pkg;

    // Debounce run tracker states
    typedef enum logic [1:0] {
        RA_IDLE  = 2'd0,   // no disagreeing sample pending
        RA_SEEN1 = 2'd1,   // one disagreeing sample seen
        RA_SEEN2 = 2'd2    // two disagreeing samples seen
    } ra_state_e;

    localparam int unsigned RA_SHALLOW_RUN = 2;
    localparam int unsigned RA_DEEP_RUN    = 3;

endpackage

// File: rtl/e1ra_slot_tap.sv
module e1ra_slot_tap #(
    parameter int unsigned TS_BITS   = 8,
    parameter int unsigned A_BIT_POS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nfas_strobe,
    input  logic rx_bit,
    output logic tap_fire,
    output logic tap_bit
);

    localparam int unsigned PW      = (TS_BITS > 1) ? $clog2(TS_BITS) : 1;
    localparam logic [PW-1:0] POS_LAST = PW'(TS_BITS - 1);
    localparam logic [PW-1:0] POS_TAP  = PW'(A_BIT_POS);

    logic [PW-1:0] pos_q;

    // Position inside the strobe window; cleared whenever the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!nfas_strobe) begin
            pos_q <= '0;
        end else if (pos_q != POS_LAST) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign tap_fire = nfas_strobe && (pos_q == POS_TAP);
    assign tap_bit  = rx_bit;

endmodule

// File: rtl/e1ra_debounce_fsm.sv
module e1ra_debounce_fsm
    import e1ra_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      align_ok,
    input  logic      deep_sel,
    input  logic      tap_fire,
    input  logic      tap_bit,
    output logic      alarm_o,
    output ra_state_e state_o
);

    ra_state_e state_q, state_d;
    logic      commit;
    logic      alarm_q;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        if (!align_ok) begin
            state_d = RA_IDLE;                          // ALIGN_CLEAR
        end else if (tap_fire) begin
            if (tap_bit == alarm_q) begin
                state_d = RA_IDLE;                      // AGREE_CLEAR
            end else begin
                unique case (state_q)
                    RA_IDLE: begin
                        state_d = RA_SEEN1;             // IDLE_TO_SEEN1
                    end
                    RA_SEEN1: begin
                        if (deep_sel) begin
                            state_d = RA_SEEN2;         // SEEN1_TO_SEEN2
                        end else begin
                            commit  = 1'b1;             // SEEN1_COMMIT
                            state_d = RA_IDLE;
                        end
                    end
                    RA_SEEN2: begin
                        commit  = 1'b1;                 // SEEN2_COMMIT
                        state_d = RA_IDLE;
                    end
                    default: begin
                        state_d = RA_IDLE;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (commit) begin
            alarm_q <= tap_bit;
        end
    end

    assign alarm_o = alarm_q;
    assign state_o = state_q;

endmodule

// File: rtl/e1_remote_alarm_debounce.sv
module e1_remote_alarm_debounce
    import e1ra_pkg::*;
#(
    parameter int unsigned TS_BITS   = 8,
    parameter int unsigned A_BIT_POS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic nfas_strobe,
    input  logic deep_sel,
    input  logic align_ok,
    output logic remote_alarm
);

    logic      tap_fire;
    logic      tap_bit;
    ra_state_e fsm_state;

    e1ra_slot_tap #(
        .TS_BITS   (TS_BITS),
        .A_BIT_POS (A_BIT_POS)
    ) u_tap (
        .clk         (clk),
        .rst_n       (rst_n),
        .nfas_strobe (nfas_strobe),
        .rx_bit      (rx_bit),
        .tap_fire    (tap_fire),
        .tap_bit     (tap_bit)
    );

    e1ra_debounce_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .align_ok (align_ok),
        .deep_sel (deep_sel),
        .tap_fire (tap_fire),
        .tap_bit  (tap_bit),
        .alarm_o  (remote_alarm),
        .state_o  (fsm_state)
    );

endmodule

// File: rtl/e1ra_checker.sv
module e1ra_checker
    import e1ra_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      rx_bit,
    input logic      nfas_strobe,
    input logic      deep_sel,
    input logic      align_ok,
    input logic      tap_fire,
    input ra_state_e state,
    input logic      remote_alarm
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !remote_alarm);                                    // R1

    AST_SHALLOW_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_fire && align_ok && !deep_sel && state == RA_SEEN1 && rx_bit != remote_alarm)
        |=> (remote_alarm == $past(rx_bit)));                         // R3

    AST_FIRST_NEVER_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_fire && state == RA_IDLE) |=> $stable(remote_alarm));    // R5

    AST_DEEP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_fire && deep_sel && state == RA_SEEN1) |=> $stable(remote_alarm)); // R4

    AST_GAP_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!nfas_strobe && align_ok) |=> ($stable(state) && $stable(remote_alarm))); // R6

    AST_ALIGN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !align_ok |=> ($stable(remote_alarm) && state == RA_IDLE));   // R7

    AST_CHANGE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remote_alarm) |-> ($past(tap_fire) && remote_alarm == $past(rx_bit))); // R9

endmodule

bind e1_remote_alarm_debounce e1ra_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_bit       (rx_bit),
    .nfas_strobe  (nfas_strobe),
    .deep_sel     (deep_sel),
    .align_ok     (align_ok),
    .tap_fire     (tap_fire),
    .state        (fsm_state),
    .remote_alarm (remote_alarm)
);

// File: tb/test_e1_remote_alarm_debounce.sv
module test_e1_remote_alarm_debounce;

    localparam int CLK_NS = 10;
    localparam int WIN    = 8;
    localparam int TAPPOS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic nfas_strobe = 1'b0;
    logic deep_sel = 1'b0;
    logic align_ok = 1'b1;
    logic remote_alarm;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    logic pre_s, post_s;

    // behavioural model state
    int  m_pos = 0;
    int  m_run = 0;
    bit  m_prev = 1'b0;
    bit  m_out = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    e1_remote_alarm_debounce i_e1_remote_alarm_debounce (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_bit       (rx_bit),
        .nfas_strobe  (nfas_strobe),
        .deep_sel     (deep_sel),
        .align_ok     (align_ok),
        .remote_alarm (remote_alarm)
    );

    // reference model, updated at each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_run = 0; m_prev = 1'b0; m_out = 1'b0;
        end else begin
            if (!align_ok) begin
                m_run = 0;
            end else if (nfas_strobe && m_pos == TAPPOS) begin
                if (m_run > 0 && rx_bit == m_prev) m_run = m_run + 1;
                else m_run = 1;
                m_prev = rx_bit;
                if (rx_bit != m_out && m_run >= (deep_sel ? 3 : 2)) m_out = rx_bit;
            end
            if (!nfas_strobe) m_pos = 0;
            else if (m_pos < WIN - 1) m_pos = m_pos + 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        compared++;
        if (remote_alarm !== m_out) begin
            mismatched++;
            $display("FAIL %s per-clock: actual=%b expected=%b at %0t", cur_req, remote_alarm, m_out, $time);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s directed: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One NFAS time slot 0 window: alarm bit at the tap, inverse elsewhere, then a strobe-low gap
    task automatic frame(input bit a, input bit sel, input bit aln, input int gap);
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (k == TAPPOS) pre_s = remote_alarm;
            if (k == TAPPOS + 1) post_s = remote_alarm;
            nfas_strobe = 1'b1;
            rx_bit = (k == TAPPOS) ? a : ~a;
            deep_sel = sel;
            align_ok = aln;
        end
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            nfas_strobe = 1'b0;
            rx_bit = k[0] ^ a;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        mismatched++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        bit last;
        repeat (3) @(negedge clk);
        chk("R1", remote_alarm, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", remote_alarm, 1'b0);

        cur_req = "R3";
        frame(1, 0, 1, 12);
        chk("R3", remote_alarm, 1'b0);
        chk("R2", remote_alarm, 1'b0);   // neighbours carried 0 in every bit but the tap
        frame(1, 0, 1, 12);
        chk("R3", remote_alarm, 1'b1);
        chk("R9", pre_s, 1'b0);
        chk("R9", post_s, 1'b1);

        cur_req = "R4";
        frame(0, 1, 1, 12);
        frame(0, 1, 1, 12);
        chk("R4", remote_alarm, 1'b1);
        frame(0, 1, 1, 12);
        chk("R4", remote_alarm, 1'b0);
        chk("R9", post_s, 1'b0);

        cur_req = "R5";
        frame(1, 1, 1, 12);
        frame(0, 1, 1, 12);
        frame(1, 1, 1, 12);
        frame(1, 1, 1, 12);
        chk("R5", remote_alarm, 1'b0);
        frame(1, 1, 1, 12);
        chk("R5", remote_alarm, 1'b1);

        cur_req = "R7";
        frame(0, 0, 1, 12);
        frame(0, 0, 0, 12);
        chk("R7", remote_alarm, 1'b1);
        frame(0, 0, 1, 12);
        chk("R7", remote_alarm, 1'b1);
        frame(0, 0, 1, 12);
        chk("R7", remote_alarm, 1'b0);

        cur_req = "R6";
        frame(1, 0, 1, 300);
        chk("R6", remote_alarm, 1'b0);
        frame(1, 0, 1, 12);
        chk("R6", remote_alarm, 1'b1);

        cur_req = "R8";
        frame(0, 0, 1, 12);
        frame(0, 1, 1, 12);
        chk("R8", remote_alarm, 1'b1);
        frame(0, 1, 1, 12);
        chk("R8", remote_alarm, 1'b0);
        frame(1, 1, 1, 12);
        frame(1, 1, 1, 12);
        chk("R8", remote_alarm, 1'b0);
        frame(1, 0, 1, 12);
        chk("R8", remote_alarm, 1'b1);

        cur_req = "R2";
        last = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 3) == 0) last = ~last;
            frame(last, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0), 2 + $urandom_range(0, 20));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule